// File: doc/BRIEF.md
# Display Blanking Interrupt Event Generator

This block watches the video timing of an on-screen-display controller and turns it into two interrupt request pulses for the CPU's interrupt controller. The first, the busy event, marks the moment the display enters a blanking interval. That is when display memory can be rewritten without visible tearing. A mode input picks whether this happens once per active line, at the start of horizontal blanking, or once per field, at the start of vertical blanking.

The second, the caption event, supports closed-caption acquisition. A line counter is cleared at each field start and advanced by each horizontal sync. When acquisition is enabled, the caption event fires on the horizontal sync that closes the line whose number equals the programmed slice line.

All timing inputs are registered once at the block edge. Rising edges are found from that registered copy and its previous value, and both outputs are registered. An input change sampled at clock edge k therefore shows up as a one-cycle output pulse after edge k+1.

Top module: `osd_blank_irq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both request outputs are low and the line count is zero.
- R2: With `mode_vert_i` = 0 (per-line mode), every rising edge of `hblank_i` that happens while `vblank_i` is low gives exactly one `busy_irq_o` pulse. The pulse is high after the second clock edge that samples `hblank_i` high.
- R3: In per-line mode, a rising edge of `hblank_i` sampled while `vblank_i` is high gives no busy pulse.
- R4: With `mode_vert_i` = 1 (per-field mode), every rising edge of `vblank_i` gives one busy pulse, with the same latency as R2. Horizontal blanking edges give no busy pulse in this mode.
- R5: A change of `mode_vert_i` alone, with the blanking inputs steady, gives no pulse. The new mode governs the next blanking edge.
- R6: Each request pulse is high for exactly one clock, however long the blanking or sync input stays high.
- R7: A rising edge of `field_start_i` clears the line count to 0. Any other rising edge of `hsync_i` adds one to the count, which saturates at 2^LINE_W-1.
- R8: With `cc_enable_i` = 1, a rising edge of `hsync_i` that arrives while the line count equals `slice_line_i` gives one `cc_irq_o` pulse, with the same latency as R2.
- R9: With `cc_enable_i` = 0, `cc_irq_o` stays low.
- R10: When rising edges of `field_start_i` and `hsync_i` are sampled in the same cycle, the field start wins. The count goes to 0 and no caption pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hblank_i | input | 1 | Horizontal blanking level |
| vblank_i | input | 1 | Vertical blanking level |
| hsync_i | input | 1 | Horizontal sync level |
| field_start_i | input | 1 | Field start indication, rising edge active |
| mode_vert_i | input | 1 | Busy event mode: 0 per line, 1 per field |
| slice_line_i | input | LINE_W | Line number that raises the caption event |
| cc_enable_i | input | 1 | Caption acquisition enable |
| busy_irq_o | output | 1 | Display-busy request pulse |
| cc_irq_o | output | 1 | Caption-data-ready request pulse |

## Verification
The busy event is driven with complete fields built from vertical-blanking lines followed by active lines. In per-line mode these show that only active lines count. In per-field mode they show that horizontal edges are ignored. Flipping the mode while blanking is held steady separates a true edge event from a level or mode-change artefact. The caption path is tried with a matching slice line, with acquisition disabled, with field start and sync arriving together (which shows the precedence), and with a run of more than 2^LINE_W syncs that exposes counter saturation. A behavioural model compares both outputs on every clock.

// File: rtl/osd_irq_pkg.sv
`timescale 1ns/1ps
package osd_irq_pkg;
  // One sampled copy of the video timing inputs
  typedef struct packed {
    logic hblank;
    logic vblank;
    logic hsync;
    logic fstart;
  } vid_t;
endpackage

// File: rtl/osd_irq_sampler.sv
`timescale 1ns/1ps
module osd_irq_sampler
  import osd_irq_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  vid_t              vid_i,
  input  logic              mode_i,
  input  logic              cc_en_i,
  input  logic [LINE_W-1:0] slice_i,
  output vid_t              vid_cur_o,
  output vid_t              vid_prev_o,
  output logic              mode_o,
  output logic              cc_en_o,
  output logic [LINE_W-1:0] slice_o
);
  vid_t cur_q, prev_q;
  logic mode_q, cc_en_q;
  logic [LINE_W-1:0] slice_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      prev_q  <= '0;
      mode_q  <= 1'b0;
      cc_en_q <= 1'b0;
      slice_q <= '0;
    end else begin
      cur_q   <= vid_i;
      prev_q  <= cur_q;
      mode_q  <= mode_i;
      cc_en_q <= cc_en_i;
      slice_q <= slice_i;
    end
  end

  assign vid_cur_o  = cur_q;
  assign vid_prev_o = prev_q;
  assign mode_o     = mode_q;
  assign cc_en_o    = cc_en_q;
  assign slice_o    = slice_q;
endmodule

// File: rtl/osd_line_counter.sv
`timescale 1ns/1ps
module osd_line_counter #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_rise_i,
  input  logic              hs_rise_i,
  output logic [LINE_W-1:0] line_o
);
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic [LINE_W-1:0] line_q, line_d;
  logic              line_en;

  always_comb begin
    line_en = fs_rise_i | hs_rise_i;
    line_d  = line_q;
    if (fs_rise_i)
      line_d = '0;
    else if (hs_rise_i && line_q != LINE_MAX)
      line_d = line_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      line_q <= '0;
    else if (line_en)
      line_q <= line_d;
  end

  assign line_o = line_o_w();
  function automatic logic [LINE_W-1:0] line_o_w();
    return line_q;
  endfunction

  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fs_rise_i |=> line_q == '0); // R7
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rise_i && !fs_rise_i && line_q != LINE_MAX) |=> line_q == LINE_W'($past(line_q) + 1'b1)); // R7
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_rise_i && !fs_rise_i) |=> $stable(line_q)); // R7
endmodule

// File: rtl/osd_busy_event.sv
`timescale 1ns/1ps
module osd_busy_event (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_vert_i,
  input  logic h_rise_i,
  input  logic v_rise_i,
  input  logic v_level_i,
  output logic busy_o
);
  logic busy_q, busy_d;

  always_comb begin
    if (mode_vert_i)
      busy_d = v_rise_i;
    else
      busy_d = h_rise_i & ~v_level_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      busy_q <= 1'b0;
    else
      busy_q <= busy_d;
  end

  assign busy_o = busy_q;

  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q); // R6
  AST_BUSY_TEXT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_vert_i && v_level_i) |=> !busy_q); // R3
  AST_BUSY_VERT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_vert_i && !v_rise_i) |=> !busy_q); // R4
endmodule

// File: rtl/osd_caption_event.sv
`timescale 1ns/1ps
module osd_caption_event #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cc_en_i,
  input  logic              hs_rise_i,
  input  logic              fs_rise_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] slice_i,
  output logic              cc_o
);
  logic cc_q, cc_d;

  always_comb begin
    cc_d = cc_en_i & hs_rise_i & ~fs_rise_i & (line_i == slice_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cc_q <= 1'b0;
    else
      cc_q <= cc_d;
  end

  assign cc_o = cc_q;

  AST_CC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cc_q |=> !cc_q); // R6
  AST_CC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_en_i |=> !cc_q); // R9
  AST_CC_FS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fs_rise_i |=> !cc_q); // R10
endmodule

// File: rtl/osd_blank_irq.sv
`timescale 1ns/1ps
module osd_blank_irq
  import osd_irq_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hblank_i,
  input  logic              vblank_i,
  input  logic              hsync_i,
  input  logic              field_start_i,
  input  logic              mode_vert_i,
  input  logic [LINE_W-1:0] slice_line_i,
  input  logic              cc_enable_i,
  output logic              busy_irq_o,
  output logic              cc_irq_o
);
  vid_t vid_in, vid_cur, vid_prev, vid_rise;
  logic mode_q, cc_en_q;
  logic [LINE_W-1:0] slice_q, line_cnt;

  always_comb begin
    vid_in.hblank = hblank_i;
    vid_in.vblank = vblank_i;
    vid_in.hsync  = hsync_i;
    vid_in.fstart = field_start_i;
    vid_rise      = vid_cur & ~vid_prev;
  end

  osd_irq_sampler #(.LINE_W(LINE_W)) u_sampler (
    .clk(clk), .rst_n(rst_n), .vid_i(vid_in), .mode_i(mode_vert_i),
    .cc_en_i(cc_enable_i), .slice_i(slice_line_i), .vid_cur_o(vid_cur),
    .vid_prev_o(vid_prev), .mode_o(mode_q), .cc_en_o(cc_en_q), .slice_o(slice_q)
  );

  osd_line_counter #(.LINE_W(LINE_W)) u_lines (
    .clk(clk), .rst_n(rst_n), .fs_rise_i(vid_rise.fstart),
    .hs_rise_i(vid_rise.hsync), .line_o(line_cnt)
  );

  osd_busy_event u_busy (
    .clk(clk), .rst_n(rst_n), .mode_vert_i(mode_q), .h_rise_i(vid_rise.hblank),
    .v_rise_i(vid_rise.vblank), .v_level_i(vid_cur.vblank), .busy_o(busy_irq_o)
  );

  osd_caption_event #(.LINE_W(LINE_W)) u_caption (
    .clk(clk), .rst_n(rst_n), .cc_en_i(cc_en_q), .hs_rise_i(vid_rise.hsync),
    .fs_rise_i(vid_rise.fstart), .line_i(line_cnt), .slice_i(slice_q), .cc_o(cc_irq_o)
  );

  AST_MODE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!vid_rise.hblank && !vid_rise.vblank) |=> !busy_irq_o); // R5
  AST_RESET_FIRST: assert property (@(posedge clk)
    !rst_n |=> (!busy_irq_o && !cc_irq_o)); // R1
endmodule

// File: tb/test_osd_blank_irq.sv
`timescale 1ns/1ps
module test_osd_blank_irq;
  localparam int LW = 10;
  localparam int LMAX = (1 << LW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic hblank, vblank, hsync, fstart, mode, cc_en;
  logic [LW-1:0] slice;
  logic busy_o, cc_o;

  always #2.5 clk = ~clk;

  osd_blank_irq #(.LINE_W(LW)) i_osd_blank_irq (
    .clk(clk), .rst_n(rst_n), .hblank_i(hblank), .vblank_i(vblank),
    .hsync_i(hsync), .field_start_i(fstart), .mode_vert_i(mode),
    .slice_line_i(slice), .cc_enable_i(cc_en), .busy_irq_o(busy_o), .cc_irq_o(cc_o)
  );

  int tests = 0, fails = 0;
  int busy_cnt = 0, cc_cnt = 0;
  bit done = 1'b0;

  // Behavioural reference: sampled history and expected outputs
  int h1, h2, v1, v2, s1, s2, f1, f2, m1, e1, sl1, line;
  int exp_busy, exp_cc;

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; v1 = 0; v2 = 0; s1 = 0; s2 = 0; f1 = 0; f2 = 0;
      m1 = 0; e1 = 0; sl1 = 0; line = 0; exp_busy = 0; exp_cc = 0;
    end else begin
      if (m1 != 0) exp_busy = (v1 == 1 && v2 == 0) ? 1 : 0;
      else         exp_busy = (h1 == 1 && h2 == 0 && v1 == 0) ? 1 : 0;
      exp_cc = 0;
      if (f1 == 1 && f2 == 0) line = 0;
      else if (s1 == 1 && s2 == 0) begin
        if (e1 != 0 && line == sl1) exp_cc = 1;
        if (line < LMAX) line = line + 1;
      end
      h2 = h1; v2 = v1; s2 = s1; f2 = f1;
      h1 = int'(hblank); v1 = int'(vblank); s1 = int'(hsync); f1 = int'(fstart);
      m1 = int'(mode); e1 = int'(cc_en); sl1 = int'(slice);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (int'(busy_o) != exp_busy) begin
        fails++;
        if (m1 != 0) $display("FAIL R4 busy per-field: got %0d exp %0d at %0t", busy_o, exp_busy, $time);
        else         $display("FAIL R2 busy per-line: got %0d exp %0d at %0t", busy_o, exp_busy, $time);
      end
      tests++;
      if (int'(cc_o) != exp_cc) begin
        fails++;
        $display("FAIL R8 caption: got %0d exp %0d at %0t", cc_o, exp_cc, $time);
      end
      if (busy_o) busy_cnt++;
      if (cc_o) cc_cnt++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic do_line(input logic vb);
    vblank = vb; hblank = 1'b1; hsync = 1'b1; step(2);
    hsync = 1'b0; step(4);
    hblank = 1'b0; step(10);
  endtask

  task automatic do_field(input int nv, input int na);
    fstart = 1'b1; step(1); fstart = 1'b0; step(1);
    for (int i = 0; i < nv; i++) do_line(1'b1);
    for (int i = 0; i < na; i++) do_line(1'b0);
    step(4);
  endtask

  initial begin
    rst_n = 1'b0; hblank = 0; vblank = 0; hsync = 0; fstart = 0;
    mode = 0; cc_en = 0; slice = '0;
    step(3);
    check("R1 busy in reset", int'(busy_o), 0);
    check("R1 cc in reset", int'(cc_o), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy_o), 0);
    check("R1 cc after reset", int'(cc_o), 0);

    // Per-line mode, caption on line 4
    busy_cnt = 0; cc_cnt = 0; cc_en = 1; slice = LW'(4);
    do_field(3, 5);
    check("R2 per-line busy count", busy_cnt, 5);
    check("R3 vblank lines suppressed", busy_cnt, 5);
    check("R8 caption count", cc_cnt, 1);

    // Per-field mode over two fields
    busy_cnt = 0; mode = 1; step(2);
    do_field(3, 5); do_field(3, 5);
    check("R4 per-field busy count", busy_cnt, 2);

    // Mode flips with blanking held high
    busy_cnt = 0; vblank = 1; hblank = 1; step(4);
    busy_cnt = 0;
    mode = 0; step(4); mode = 1; step(4); mode = 0; step(4);
    check("R5 mode flip no pulse", busy_cnt, 0);
    check("R6 held blanking single pulse", busy_cnt, 0);
    vblank = 0; hblank = 0; step(4);
    busy_cnt = 0;
    hblank = 1; step(20);
    check("R5 new mode on next edge", busy_cnt, 1);
    check("R6 long hblank one pulse", busy_cnt, 1);
    hblank = 0; step(4);

    // Caption disabled
    cc_cnt = 0; cc_en = 0; slice = LW'(2);
    do_field(1, 4);
    check("R9 disabled caption", cc_cnt, 0);

    // Field start and hsync together
    cc_en = 1; slice = '0; cc_cnt = 0;
    fstart = 1; step(1); fstart = 0; step(2);
    fstart = 1; hsync = 1; step(1); fstart = 0; hsync = 0; step(4);
    check("R10 coincident no caption", cc_cnt, 0);
    hsync = 1; step(1); hsync = 0; step(4);
    check("R10 line zero after coincidence", cc_cnt, 1);

    // Saturation of the line count
    cc_cnt = 0; slice = LW'(LMAX);
    fstart = 1; step(1); fstart = 0; step(1);
    for (int i = 0; i < LMAX + 8; i++) begin
      hsync = 1; step(1); hsync = 0; step(1);
    end
    step(4);
    check("R7 saturated line count", cc_cnt, 8);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule